// File: doc/BRIEF.md
# Random Output Word Queue Controller

This block hands out generated random words one at a time through a single read-only output register. A generation request makes eight 32-bit words available at once. A reseed request reloads the internal generator state from a 128-bit seed input and leaves the queue empty. Software-visible status is a 3-bit availability count, which saturates at 4 while more words are buffered, together with a one-cycle done pulse and a sticky generation-budget error flag.

The words come from a simple 128-bit xorshift generator; cryptographic strength is not a goal. In automatic mode, which means the stored start bit is set and single-shot is clear, a read that leaves three or fewer words refills the queue to eight words. Reads while the block is held in reset, or while the queue is empty, return a fixed marker word and change nothing.

The block has two reset sources besides the chip reset: a hold bit, which comes out of chip reset set, and a soft-reset bit stored from the control write. A budget counter limits the number of generations between reseeds. When the budget is spent, the next generation first forces a reseed from the seed input.

Top module: `rng_word_queue`

## Requirements
- R1: After chip reset `avail_cnt` is 0, `done` is 0, `gen_err` is 0, `rd_data` is 0, and the hold bit is 1, so the block is in reset.
- R2: A control write with start=1, mode=1 (`ctl_gen`), soft-reset=0 while the block is out of reset makes 8 words available. `avail_cnt` reads 4 and `done` is high for exactly the one cycle after the write.
- R3: A control write with start=1, mode=0 (reseed) while the block is out of reset empties the queue (`avail_cnt`=0), pulses `done`, restores the full generation budget and loads the generator lanes from `seed_in`. Lane 0 takes bits [31:0], lane 1 [63:32], lane 2 [95:64] and lane 3 [127:96].
- R4: Each successful read removes one word. `avail_cnt` equals the remaining word count when fewer than 4 remain, and 4 otherwise.
- R5: A successful read returns lane 3 and then advances the generator: t = l0 ^ (l0<<11); l0,l1,l2 take l1,l2,l3; l3 becomes l3 ^ (l3>>19) ^ t ^ (t>>8). `rd_data` changes only on a read.
- R6: A read while in reset, or with no word available, returns 32'h00000BAD and changes no other state.
- R7: After a successful read that leaves 3 or fewer words, the queue refills to 8 words if the stored start bit is 1, the stored single-shot bit is 0, and no control write is in the same cycle. With single-shot set or start clear there is no refill.
- R8: The generation budget is 2^BUDGET_LOG2 generations per reseed. A generation with the budget spent first reloads the generator from `seed_in` and then generates, and it sets the sticky `gen_err`.
- R9: The block is in reset while the hold bit is 1 or the stored soft-reset bit is 1. A control write while the hold bit is 1 stores its fields but takes no action: no `done` and no change of count.
- R10: A control write with soft-reset=1 while the hold bit is 0 clears the word count and `gen_err`, gives no `done`, and blocks reads until a later control write clears soft-reset.
- R11: A hold write that changes the hold bit from 0 to 1 clears the word count, `gen_err` and the stored start, single-shot and soft-reset bits. This takes priority over a control write in the same cycle.
- R12: When a read and a control write fall in the same cycle, the read is served from the state before that cycle. The control action is applied after it, and no automatic refill happens in that cycle.
- R13: A control write with start=0 and soft-reset=0 changes no count and gives no `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low chip reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_start | input | 1 | Start bit of the control write |
| ctl_gen | input | 1 | Mode: 1 generate, 0 reseed |
| ctl_single | input | 1 | Single-shot mode (no automatic refill) |
| ctl_soft_rst | input | 1 | Soft-reset bit of the control write |
| hold_wr | input | 1 | Hold register write strobe |
| hold_val | input | 1 | Value written to the hold bit |
| seed_in | input | 128 | Seed source for reseeds |
| rd_en | input | 1 | Read strobe on the output register |
| rd_data | output | 32 | Word returned by the last read |
| avail_cnt | output | 3 | Saturated count of available words |
| done | output | 1 | One-cycle pulse after a generate or reseed action |
| gen_err | output | 1 | Sticky flag: a generation hit a spent budget |

## Verification
A read strobe and a control write can fall in the same cycle. The read is then served from the old state, and the generate, reseed or soft-reset action lands on top of it. The bench provokes this collision on purpose with a short queue, once followed by a generate and once by a reseed. It also lets random stimulus bring many more collisions. In every case a bench-side model ordered read-first, then control, then hold judges the returned word, the count and the generator state that the following reads reveal.

// File: rtl/rwq_pkg.sv
package rwq_pkg;
  localparam logic [31:0] EMPTY_MARK = 32'h0000_0BAD;
  localparam int unsigned XS_LANES = 4;
  localparam logic [127:0] XS_BOOT = 128'h9E37_79B9_7F4A_7C15_2545_F491_4F6C_DD1D;
endpackage

// File: rtl/rwq_xorshift.sv
module rwq_xorshift #(
  parameter int WORD_W = 32,
  parameter int SH_A   = 11,
  parameter int SH_B   = 8,
  parameter int SH_C   = 19,
  parameter logic [4*WORD_W-1:0] BOOT = rwq_pkg::XS_BOOT
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic                  adv,
  input  logic [4*WORD_W-1:0]   load_val,
  output logic [WORD_W-1:0]     word
);
  localparam int LANES = rwq_pkg::XS_LANES;

  logic [WORD_W-1:0] lane_q [LANES];
  logic [WORD_W-1:0] lane_d [LANES];
  logic [WORD_W-1:0] t_mix;
  logic              lane_en;

  assign lane_en = load | adv;

  always_comb begin
    t_mix = lane_q[0] ^ (lane_q[0] << SH_A);
    for (int i = 0; i < LANES; i++) lane_d[i] = lane_q[i];
    if (load) begin
      for (int i = 0; i < LANES; i++) lane_d[i] = load_val[i*WORD_W +: WORD_W];
    end else if (adv) begin
      lane_d[0] = lane_q[1];
      lane_d[1] = lane_q[2];
      lane_d[2] = lane_q[3];
      lane_d[3] = lane_q[3] ^ (lane_q[3] >> SH_C) ^ t_mix ^ (t_mix >> SH_B);
    end
  end

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       lane_q[g] <= BOOT[g*WORD_W +: WORD_W];
        else if (lane_en) lane_q[g] <= lane_d[g];
      end
    end
  endgenerate

  assign word = lane_q[LANES-1];

  // R3
  xs_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> word == $past(load_val[3*WORD_W +: WORD_W]));
endmodule

// File: rtl/rwq_budget.sv
module rwq_budget #(
  parameter int LOG2 = 48
) (
  input  logic clk,
  input  logic rst_n,
  input  logic reload,
  input  logic consume,
  output logic forced
);
  localparam int CW = LOG2 + 1;
  localparam logic [CW-1:0] FULL = CW'(1) << LOG2;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          spent, cnt_en;

  assign spent  = (cnt_q == '0);
  assign forced = consume & spent;
  assign cnt_en = reload | consume;

  always_comb begin
    cnt_d = cnt_q;
    if (reload)  cnt_d = FULL;
    if (consume) cnt_d = (spent ? FULL : cnt_q) - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= FULL;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R8
  bud_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL);
  // R8
  bud_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
    forced |=> cnt_q == FULL - CW'(1));
endmodule

// File: rtl/rwq_queue_ctrl.sv
module rwq_queue_ctrl #(
  parameter int WORD_W    = 32,
  parameter int GEN_WORDS = 8,
  parameter int REFILL_AT = 3,
  parameter int WCNT_W    = $clog2(GEN_WORDS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              rd_block,
  input  logic              auto_en,
  input  logic              act_gen,
  input  logic              act_reseed,
  input  logic              act_clear,
  input  logic              hold_clear,
  input  logic              forced,
  input  logic [WORD_W-1:0] cur_word,
  output logic [WORD_W-1:0] rd_data,
  output logic [WCNT_W-1:0] words,
  output logic              done,
  output logic              gen_err,
  output logic              xs_adv,
  output logic              gen_any
);
  localparam logic [WCNT_W-1:0] FULLQ = WCNT_W'(GEN_WORDS);
  localparam logic [WCNT_W-1:0] LOWQ  = WCNT_W'(REFILL_AT);
  localparam logic [WORD_W-1:0] MARK  = WORD_W'(rwq_pkg::EMPTY_MARK);

  logic [WCNT_W-1:0] words_q, words_d, left;
  logic [WORD_W-1:0] rd_q, rd_d;
  logic              done_q, done_d, err_q, err_d;
  logic              rd_ok, auto_fire, words_en, err_en;

  assign rd_ok     = rd_en & ~rd_block & (words_q != '0);
  assign left      = words_q - WCNT_W'(1);
  assign auto_fire = rd_ok & auto_en & (left <= LOWQ);
  assign gen_any   = act_gen | auto_fire;
  assign xs_adv    = rd_ok;

  always_comb begin
    words_d = words_q;
    if (hold_clear | act_clear) words_d = '0;
    else if (gen_any)           words_d = FULLQ;
    else if (act_reseed)        words_d = '0;
    else if (rd_ok)             words_d = left;
  end
  assign words_en = hold_clear | act_clear | gen_any | act_reseed | rd_ok;

  always_comb begin
    err_d = err_q;
    if (hold_clear | act_clear) err_d = 1'b0;
    else if (forced)            err_d = 1'b1;
  end
  assign err_en = hold_clear | act_clear | forced;

  assign rd_d   = rd_ok ? cur_word : MARK;
  assign done_d = act_gen | act_reseed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      words_q <= '0;
      rd_q    <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= done_d;
      if (words_en) words_q <= words_d;
      if (rd_en)    rd_q    <= rd_d;
      if (err_en)   err_q   <= err_d;
    end
  end

  assign words   = words_q;
  assign rd_data = rd_q;
  assign done    = done_q;
  assign gen_err = err_q;

  // R4
  words_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    words_q <= FULLQ);
  // R6
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && (rd_block || words_q == '0) |=> rd_data == MARK);
  // R6
  empty_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && words_q == '0 && !act_gen && !act_reseed && !act_clear && !hold_clear
    |=> words_q == '0);
  // R7
  refill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ok && auto_en && words_q <= LOWQ + WCNT_W'(1) && !hold_clear && !act_clear
    |=> words_q == FULLQ);
endmodule

// File: rtl/rng_word_queue.sv
module rng_word_queue #(
  parameter int WORD_W      = 32,
  parameter int GEN_WORDS   = 8,
  parameter int CNT_W       = 3,
  parameter int CNT_SAT     = 4,
  parameter int REFILL_AT   = 3,
  parameter int BUDGET_LOG2 = 48
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ctl_wr,
  input  logic                ctl_start,
  input  logic                ctl_gen,
  input  logic                ctl_single,
  input  logic                ctl_soft_rst,
  input  logic                hold_wr,
  input  logic                hold_val,
  input  logic [4*WORD_W-1:0] seed_in,
  input  logic                rd_en,
  output logic [WORD_W-1:0]   rd_data,
  output logic [CNT_W-1:0]    avail_cnt,
  output logic                done,
  output logic                gen_err
);
  localparam int WCNT_W = $clog2(GEN_WORDS + 1);
  localparam logic [WCNT_W-1:0] SATQ = WCNT_W'(CNT_SAT);

  logic start_q, single_q, soft_q, hold_q;
  logic start_d, single_d, soft_d, hold_d;
  logic cfg_en, hold_rise;
  logic ctl_ok, act_gen, act_reseed, act_clear;
  logic rd_block, auto_en, forced, gen_any, xs_adv, xs_load;
  logic [WORD_W-1:0] cur_word;
  logic [WCNT_W-1:0] words;

  assign hold_rise  = hold_wr & hold_val & ~hold_q;
  assign ctl_ok     = ctl_wr & ~hold_q;
  assign act_clear  = ctl_ok & ctl_soft_rst;
  assign act_gen    = ctl_ok & ~ctl_soft_rst & ctl_start & ctl_gen;
  assign act_reseed = ctl_ok & ~ctl_soft_rst & ctl_start & ~ctl_gen;
  assign rd_block   = hold_q | soft_q;
  assign auto_en    = start_q & ~single_q & ~ctl_wr;
  assign xs_load    = act_reseed | forced;

  always_comb begin
    start_d  = start_q;
    single_d = single_q;
    soft_d   = soft_q;
    hold_d   = hold_wr ? hold_val : hold_q;
    if (hold_rise) begin
      start_d  = 1'b0;
      single_d = 1'b0;
      soft_d   = 1'b0;
    end else if (ctl_wr) begin
      start_d  = ctl_start;
      single_d = ctl_single;
      soft_d   = ctl_soft_rst;
    end
  end
  assign cfg_en = ctl_wr | hold_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q  <= 1'b0;
      single_q <= 1'b0;
      soft_q   <= 1'b0;
      hold_q   <= 1'b1;
    end else if (cfg_en) begin
      start_q  <= start_d;
      single_q <= single_d;
      soft_q   <= soft_d;
      hold_q   <= hold_d;
    end
  end

  rwq_xorshift #(.WORD_W(WORD_W)) u_xs (
    .clk(clk), .rst_n(rst_n), .load(xs_load), .adv(xs_adv),
    .load_val(seed_in), .word(cur_word)
  );

  rwq_budget #(.LOG2(BUDGET_LOG2)) u_bud (
    .clk(clk), .rst_n(rst_n), .reload(act_reseed), .consume(gen_any), .forced(forced)
  );

  rwq_queue_ctrl #(
    .WORD_W(WORD_W), .GEN_WORDS(GEN_WORDS), .REFILL_AT(REFILL_AT), .WCNT_W(WCNT_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_block(rd_block), .auto_en(auto_en),
    .act_gen(act_gen), .act_reseed(act_reseed), .act_clear(act_clear),
    .hold_clear(hold_rise), .forced(forced), .cur_word(cur_word),
    .rd_data(rd_data), .words(words), .done(done), .gen_err(gen_err),
    .xs_adv(xs_adv), .gen_any(gen_any)
  );

  assign avail_cnt = (words >= SATQ) ? CNT_W'(CNT_SAT) : CNT_W'(words);

  // R4
  cnt_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    avail_cnt <= CNT_W'(CNT_SAT));
  // R2
  done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(ctl_wr));
  // R9
  hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr && hold_q && !rd_en && !hold_wr |=> !done && $stable(avail_cnt));
  // R11
  hold_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_rise |=> avail_cnt == '0 && !gen_err);
endmodule

// File: tb/rng_word_queue_bench.sv
`timescale 1ns/1ps
module rng_word_queue_bench;
  localparam int BL2  = 2;
  localparam int BFUL = 1 << BL2;

  logic clk = 1'b0;
  logic rst_n;
  logic ctl_wr, ctl_start, ctl_gen, ctl_single, ctl_soft_rst;
  logic hold_wr, hold_val, rd_en;
  logic [127:0] seed_in;
  logic [31:0] rd_data;
  logic [2:0]  avail_cnt;
  logic        done, gen_err;

  always #4 clk = ~clk;

  rng_word_queue #(.BUDGET_LOG2(BL2)) u_rng_word_queue (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_start(ctl_start), .ctl_gen(ctl_gen),
    .ctl_single(ctl_single), .ctl_soft_rst(ctl_soft_rst), .hold_wr(hold_wr),
    .hold_val(hold_val), .seed_in(seed_in), .rd_en(rd_en), .rd_data(rd_data),
    .avail_cnt(avail_cnt), .done(done), .gen_err(gen_err)
  );

  int total = 0;
  int bad   = 0;

  logic [31:0] m_l [4];
  int          m_words, m_budget;
  bit          m_err, m_start, m_single, m_soft, m_hold, m_done;
  logic [31:0] m_rd;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [2:0] sat_cnt(input int w);
    return (w >= 4) ? 3'd4 : 3'(w);
  endfunction

  task automatic m_adv();
    logic [31:0] t;
    t = m_l[0] ^ (m_l[0] << 11);
    m_l[0] = m_l[1];
    m_l[1] = m_l[2];
    m_l[2] = m_l[3];
    m_l[3] = m_l[3] ^ (m_l[3] >> 19) ^ t ^ (t >> 8);
  endtask

  task automatic m_load(input logic [127:0] s);
    for (int i = 0; i < 4; i++) m_l[i] = s[i*32 +: 32];
  endtask

  task automatic m_gen(input logic [127:0] s);
    if (m_budget == 0) begin
      m_load(s);
      m_budget = BFUL;
      m_err = 1'b1;
    end
    m_budget--;
    m_words = 8;
  endtask

  task automatic m_model(input bit wr, st, gm, sg, sr, hw, hv, rd, input logic [127:0] s);
    bit ok;
    bit auto_go;
    ok = 1'b0;
    m_done = 1'b0;
    if (rd) begin
      if (m_hold || m_soft || m_words == 0) m_rd = 32'h0000_0BAD;
      else begin
        m_rd = m_l[3];
        m_adv();
        m_words--;
        ok = 1'b1;
      end
    end
    auto_go = ok && m_start && !m_single && (m_words <= 3) && !wr;
    if (wr) begin
      m_start = st; m_single = sg; m_soft = sr;
      if (!m_hold) begin
        if (sr) begin m_words = 0; m_err = 1'b0; end
        else if (st) begin
          if (gm) m_gen(s);
          else begin m_load(s); m_words = 0; m_budget = BFUL; end
          m_done = 1'b1;
        end
      end
    end else if (auto_go) m_gen(s);
    if (hw) begin
      if (!m_hold && hv) begin
        m_words = 0; m_err = 1'b0; m_start = 1'b0; m_single = 1'b0; m_soft = 1'b0;
      end
      m_hold = hv;
    end
  endtask

  task automatic step(input bit wr, st, gm, sg, sr, hw, hv, rd, input logic [127:0] s);
    ctl_wr = wr; ctl_start = st; ctl_gen = gm; ctl_single = sg; ctl_soft_rst = sr;
    hold_wr = hw; hold_val = hv; rd_en = rd; seed_in = s;
    @(posedge clk);
    #1;
    m_model(wr, st, gm, sg, sr, hw, hv, rd, s);
    @(negedge clk);
    chk("R5/R6 rd_data", rd_data, m_rd);
    chk("R4 avail_cnt", 32'(avail_cnt), 32'(sat_cnt(m_words)));
    chk("R2/R3 done", 32'(done), 32'(m_done));
    chk("R8 gen_err", 32'(gen_err), 32'(m_err));
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0, seed_in);
  endtask

  task automatic rd1();
    step(0, 0, 0, 0, 0, 0, 0, 1, seed_in);
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  localparam logic [127:0] S1 = 128'h0BAD_F00D_1357_9BDF_2468_ACE0_C0FF_EE11;
  localparam logic [127:0] S2 = 128'h7777_1111_ABCD_0123_5555_AAAA_0F0F_F0F0;

  initial begin
    logic [31:0] w0;
    void'($urandom(32'd4242));
    rst_n = 1'b0;
    ctl_wr = 0; ctl_start = 0; ctl_gen = 0; ctl_single = 0; ctl_soft_rst = 0;
    hold_wr = 0; hold_val = 0; rd_en = 0; seed_in = '0;
    m_load(rwq_pkg::XS_BOOT);
    m_words = 0; m_budget = BFUL; m_err = 0; m_start = 0; m_single = 0; m_soft = 0;
    m_hold = 1; m_done = 0; m_rd = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 avail_cnt", 32'(avail_cnt), 0);
    chk("R1 done", 32'(done), 0);
    chk("R1 gen_err", 32'(gen_err), 0);
    chk("R1 rd_data", rd_data, 0);
    // R9 read while hold set returns marker; control write ignored
    rd1();
    chk("R9 read in hold", rd_data, 32'h0000_0BAD);
    step(1, 1, 1, 0, 0, 0, 0, 0, S1);
    chk("R9 no done in hold", 32'(done), 0);
    chk("R9 count unchanged in hold", 32'(avail_cnt), 0);
    // leave hold; the stored start from the ignored write stays
    step(0, 0, 0, 0, 0, 1, 0, 0, S1);
    // R3 reseed
    step(1, 1, 0, 1, 0, 0, 0, 0, S1);
    chk("R3 done after reseed", 32'(done), 1);
    chk("R3 count after reseed", 32'(avail_cnt), 0);
    idle();
    chk("R3 done one cycle", 32'(done), 0);
    rd1();
    chk("R6 empty read", rd_data, 32'h0000_0BAD);
    // R2 generate single-shot
    step(1, 1, 1, 1, 0, 0, 0, 0, S2);
    chk("R2 count after gen", 32'(avail_cnt), 4);
    chk("R2 done", 32'(done), 1);
    rd1();
    chk("R5 first word is seed lane 3", rd_data, S1[127:96]);
    for (int k = 0; k < 3; k++) rd1();
    chk("R4 count saturated at 4 words", 32'(avail_cnt), 4);
    rd1();
    chk("R4 count 3", 32'(avail_cnt), 3);
    rd1(); rd1();
    chk("R7 single-shot no refill", 32'(avail_cnt), 1);
    rd1();
    chk("R4 count 0", 32'(avail_cnt), 0);
    rd1();
    chk("R6 drained read", rd_data, 32'h0000_0BAD);
    // R7 automatic refill
    step(1, 1, 1, 0, 0, 0, 0, 0, S2);
    for (int k = 0; k < 5; k++) rd1();
    chk("R7 auto refill", 32'(avail_cnt), 4);
    // R13 start=0 write
    step(1, 0, 1, 0, 0, 0, 0, 0, S2);
    chk("R13 no done", 32'(done), 0);
    chk("R13 count kept", 32'(avail_cnt), 4);
    // R8 budget: reseed then exceed
    step(1, 1, 0, 1, 0, 0, 0, 0, S1);
    for (int k = 0; k < BFUL; k++) step(1, 1, 1, 1, 0, 0, 0, 0, S1);
    chk("R8 no error within budget", 32'(gen_err), 0);
    step(1, 1, 1, 1, 0, 0, 0, 0, S2);
    chk("R8 error after budget", 32'(gen_err), 1);
    rd1();
    chk("R8 forced reseed word", rd_data, S2[127:96]);
    // R12 read + generate same cycle with 1 word left (single-shot)
    for (int k = 0; k < 6; k++) rd1();
    chk("R12 setup one word", 32'(avail_cnt), 1);
    w0 = m_l[3];
    step(1, 1, 1, 0, 0, 0, 0, 1, S1);
    chk("R12 read served old state", rd_data, w0);
    chk("R12 gen applied", 32'(avail_cnt), 4);
    // R12 read + reseed same cycle
    w0 = m_l[3];
    step(1, 1, 0, 0, 0, 0, 0, 1, S2);
    chk("R12 read before reseed", rd_data, w0);
    chk("R12 reseed empties", 32'(avail_cnt), 0);
    step(1, 1, 1, 1, 0, 0, 0, 0, S1);
    rd1();
    chk("R12 state from reseed seed", rd_data, S2[127:96]);
    // R10 soft reset
    step(1, 0, 0, 0, 1, 0, 0, 0, S1);
    chk("R10 count cleared", 32'(avail_cnt), 0);
    chk("R10 err cleared", 32'(gen_err), 0);
    chk("R10 no done", 32'(done), 0);
    rd1();
    chk("R10 read blocked", rd_data, 32'h0000_0BAD);
    step(1, 1, 1, 1, 0, 0, 0, 0, S1);
    chk("R10 leave soft reset", 32'(avail_cnt), 4);
    // R11 hold rising
    step(0, 0, 0, 0, 0, 1, 1, 0, S1);
    chk("R11 count cleared by hold", 32'(avail_cnt), 0);
    step(0, 0, 0, 0, 0, 1, 0, 0, S1);
    // random phase, checked every cycle against the model
    for (int n = 0; n < 6000; n++) begin
      bit wr, hw;
      wr = ($urandom % 6) == 0;
      hw = ($urandom % 250) == 0;
      step(wr, ($urandom % 4) != 0, ($urandom % 3) != 0, ($urandom % 3) == 0,
           ($urandom % 20) == 0, hw, ($urandom % 3) == 0, ($urandom % 2) == 0,
           {$urandom, $urandom, $urandom, $urandom});
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule